// File: doc/BRIEF.md
# Page ECC Accumulator for NAND Data Transfers

This block watches the byte stream that moves between a host and a NAND flash device. It builds a Hamming-style single-error-correcting code over each chunk of 256 bytes. Each accepted byte adds to two accumulators. Six column-parity bits cover the bit positions inside a byte. Sixteen line-parity bits cover the position of the byte inside the chunk. The host uses the result later to correct one flipped bit or to detect a larger error. Correction itself is done by host software and is not part of this block.

Software starts a chunk by writing the control byte 0x07. That one write turns accumulation on, clears the accumulators and selects the inverted output form. The data bytes then flow through. After 256 accepted bytes, the code is read back as three separate bytes or as one 32-bit word. The low byte of that word is the controller's status byte. In inverted form the code is the same code that the common 256-byte software Hamming corrector computes, so an erased chunk of all-ones data reads back as 0xFF 0xFF 0xFF.

Top module: `ecc_page_gen`

## Requirements
- R1: After reset the control byte (offset 5) reads 0x00, and offsets 1, 2 and 3 each read 0x00.
- R2: Column parity bit k (k = 0..5) is the XOR, over the accepted bytes, of the data bits b for which bit (k/2) of b equals (k mod 2). In raw form, bits 7:2 of the byte at offset 3 are column bits 5:0, and bits 1:0 read as 00.
- R3: Each accepted byte whose 8 bits XOR to 1 updates the line-parity bits, using the byte's index i in the chunk. For each k = 0..7 it toggles line bit 2k+1 if bit k of i is 1, and toggles line bit 2k if bit k of i is 0. Offset 1 reads line bits 15:8 and offset 2 reads line bits 7:0.
- R4: Control bit 2 selects the output form. When it is 1, offsets 1, 2 and 3 read the bitwise inverse of the stored parity, and bits 1:0 of offset 3 read 11. When it is 0, the stored values are read as they are. An all-0xFF chunk read in inverted form gives 0xFF at all three offsets.
- R5: A read at offset 0 returns a 32-bit word: bits 7:0 are the status input, bits 15:8 are offset 1, bits 23:16 are offset 2 and bits 31:24 are offset 3.
- R6: A control write with bit 1 set clears the line parity, the column parity and the byte count at the clock edge of that write. A byte presented in the same cycle is dropped. Bit 1 always reads back as 0, bit 0 reads the enable and bit 2 reads the form select.
- R7: A byte is accepted only when the enable (control bit 0), as held before that cycle, is 1. A byte presented while the enable is 0 changes neither the code nor the byte index.
- R8: After 256 accepted bytes, further bytes are ignored and the code holds until the next clear.
- R9: Writes to any offset other than 5 have no effect. Reads at offset 4 and at offsets 6 to 15 return 0.
- R10: An accepted byte is reflected in the read-back code in the cycle after the clock edge that takes it in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dat_vld | input | 1 | Data byte strobe |
| dat_byte | input | 8 | Data byte on the flash bus |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read offset |
| rd_data | output | 32 | Read data (byte reads are zero-extended) |
| sts_in | input | 8 | Controller status byte, placed in the word read |

## Verification
The bench uses the default chunk size of 256 bytes. With that size it can fill whole chunks, so it reaches the freeze after the last byte. It also checks the full 16-bit line-parity layout at offsets 1 and 2 against a model computed in the bench. Random pages are run in both the inverted and the raw output form. Directed cases cover an erased page and a clear that falls in the same cycle as a data byte. They also cover a gap in enable in the middle of a chunk, bytes sent after the chunk is full, and writes to unmapped offsets.

// File: rtl/ecc_page_pkg.sv
package ecc_page_pkg;
    localparam int BYTE_W = 8;
    localparam int COL_W  = 6;
    localparam int LP_PAD = 16;

    localparam int OFF_WORD = 0;
    localparam int OFF_LHI  = 1;
    localparam int OFF_LLO  = 2;
    localparam int OFF_COL  = 3;
    localparam int OFF_CTL  = 5;

    localparam int CTL_EN  = 0;
    localparam int CTL_CLR = 1;
    localparam int CTL_POL = 2;

    // Bit b belongs to column group k when bit (k/2) of b equals k%2.
    function automatic logic [BYTE_W-1:0] col_mask(input int k);
        logic [BYTE_W-1:0] m;
        m = '0;
        for (int b = 0; b < BYTE_W; b++) begin
            m[b] = (((b >> (k / 2)) & 1) == (k % 2));
        end
        return m;
    endfunction
endpackage

// File: rtl/ecc_byte_par.sv
module ecc_byte_par
    import ecc_page_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output logic [COL_W-1:0]  col_out,
    output logic              par_out
);
    for (genvar k = 0; k < COL_W; k++) begin : g_col
        localparam logic [BYTE_W-1:0] MASK = col_mask(k);
        assign col_out[k] = ^(byte_in & MASK);
    end
    assign par_out = ^byte_in;
endmodule

// File: rtl/ecc_line_upd.sv
module ecc_line_upd #(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic               par,
    input  logic [2*IDX_W-1:0] line_in,
    output logic [2*IDX_W-1:0] line_out
);
    for (genvar k = 0; k < IDX_W; k++) begin : g_pair
        assign line_out[2*k+1] = line_in[2*k+1] ^ (par &  idx[k]);
        assign line_out[2*k]   = line_in[2*k]   ^ (par & ~idx[k]);
    end
endmodule

// File: rtl/ecc_rd_fmt.sv
module ecc_rd_fmt
    import ecc_page_pkg::*;
#(
    parameter int LINE_W = 16,
    parameter int ADDR_W = 4,
    parameter int WORD_W = 32
) (
    input  logic [LINE_W-1:0] line,
    input  logic [COL_W-1:0]  col,
    input  logic              en,
    input  logic              pol,
    input  logic [BYTE_W-1:0] sts,
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] data
);
    logic [LP_PAD-1:0] line_pad;
    logic [BYTE_W-1:0] b_lhi;
    logic [BYTE_W-1:0] b_llo;
    logic [BYTE_W-1:0] b_col;
    logic [BYTE_W-1:0] b_ctl;

    always_comb begin
        for (int b = 0; b < LP_PAD; b++) begin
            line_pad[b] = (b < LINE_W) ? line[b] : 1'b0;
        end
        b_lhi = line_pad[15:8] ^ {BYTE_W{pol}};
        b_llo = line_pad[7:0]  ^ {BYTE_W{pol}};
        b_col = {col ^ {COL_W{pol}}, {2{pol}}};
        b_ctl = '0;
        b_ctl[CTL_EN]  = en;
        b_ctl[CTL_POL] = pol;
        data = '0;
        case (int'(addr))
            OFF_WORD: data = WORD_W'({b_col, b_llo, b_lhi, sts});
            OFF_LHI:  data = WORD_W'(b_lhi);
            OFF_LLO:  data = WORD_W'(b_llo);
            OFF_COL:  data = WORD_W'(b_col);
            OFF_CTL:  data = WORD_W'(b_ctl);
            default:  data = '0;
        endcase
    end
endmodule

// File: rtl/ecc_page_gen.sv
module ecc_page_gen
    import ecc_page_pkg::*;
#(
    parameter int CHUNK_LOG2 = 8,
    parameter int ADDR_W     = 4,
    parameter int WORD_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dat_vld,
    input  logic [7:0]        dat_byte,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic [7:0]        sts_in
);
    localparam int CHUNK  = 1 << CHUNK_LOG2;
    localparam int CNT_W  = CHUNK_LOG2 + 1;
    localparam int LINE_W = 2 * CHUNK_LOG2;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [LINE_W-1:0] line;
        logic [COL_W-1:0]  col;
        logic              en;
        logic              pol;
    } st_t;

    st_t st_d, st_q;

    logic [COL_W-1:0]  byte_col;
    logic              byte_par;
    logic [LINE_W-1:0] line_upd;

    logic [CNT_W-1:0]  cnt_q;
    logic [LINE_W-1:0] line_q;
    logic [COL_W-1:0]  col_q;
    logic              en_q;
    logic              pol_q;

    assign cnt_q  = st_q.cnt;
    assign line_q = st_q.line;
    assign col_q  = st_q.col;
    assign en_q   = st_q.en;
    assign pol_q  = st_q.pol;

    ecc_byte_par u_par (
        .byte_in (dat_byte),
        .col_out (byte_col),
        .par_out (byte_par)
    );

    ecc_line_upd #(.IDX_W(CHUNK_LOG2)) u_line (
        .idx      (st_q.cnt[CHUNK_LOG2-1:0]),
        .par      (byte_par),
        .line_in  (st_q.line),
        .line_out (line_upd)
    );

    ecc_rd_fmt #(.LINE_W(LINE_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fmt (
        .line (st_q.line),
        .col  (st_q.col),
        .en   (st_q.en),
        .pol  (st_q.pol),
        .sts  (sts_in),
        .addr (rd_addr),
        .data (rd_data)
    );

    logic ctl_wr;
    logic clr;
    logic take;

    always_comb begin
        st_d   = st_q;
        ctl_wr = wr_en && (wr_addr == ADDR_W'(OFF_CTL));
        clr    = ctl_wr && wr_data[CTL_CLR];
        take   = dat_vld && st_q.en && (st_q.cnt < CNT_W'(CHUNK)) && !clr;
        if (ctl_wr) begin
            st_d.en  = wr_data[CTL_EN];
            st_d.pol = wr_data[CTL_POL];
        end
        if (clr) begin
            st_d.cnt  = '0;
            st_d.line = '0;
            st_d.col  = '0;
        end else if (take) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.line = line_upd;
            st_d.col  = st_q.col ^ byte_col;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ecc_page_gen_chk.sv
module ecc_page_gen_chk #(
    parameter int CHUNK_LOG2 = 8,
    parameter int ADDR_W     = 4,
    parameter int WORD_W     = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  dat_vld,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [7:0]            wr_data,
    input logic [ADDR_W-1:0]     rd_addr,
    input logic [WORD_W-1:0]     rd_data,
    input logic [7:0]            sts_in,
    input logic [CHUNK_LOG2:0]   cnt_q,
    input logic [2*CHUNK_LOG2-1:0] line_q,
    input logic [5:0]            col_q,
    input logic                  en_q,
    input logic                  pol_q
);
    localparam int CHUNK = 1 << CHUNK_LOG2;
    logic clr_w;
    assign clr_w = wr_en && (wr_addr == ADDR_W'(5)) && wr_data[1];

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> (cnt_q == '0) && (line_q == '0) && (col_q == '0)); // R6
    AST_CLR_READ0: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(5)) |-> (rd_data[1] == 1'b0)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !clr_w) |=> $stable(line_q) && $stable(col_q) && $stable(cnt_q)); // R7
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == (CHUNK_LOG2+1)'(CHUNK)) && !clr_w) |=> $stable(line_q) && $stable(col_q) && $stable(cnt_q)); // R8
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= (CHUNK_LOG2+1)'(CHUNK)); // R8
    AST_COL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(3)) |-> (rd_data[1:0] == {2{pol_q}})); // R4
    AST_WORD_STS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(0)) |-> (rd_data[7:0] == sts_in)); // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_vld && !clr_w && en_q && (cnt_q < (CHUNK_LOG2+1)'(CHUNK))) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R10
endmodule

bind ecc_page_gen ecc_page_gen_chk #(
    .CHUNK_LOG2 (CHUNK_LOG2),
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dat_vld (dat_vld),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .sts_in  (sts_in),
    .cnt_q   (cnt_q),
    .line_q  (line_q),
    .col_q   (col_q),
    .en_q    (en_q),
    .pol_q   (pol_q)
);

// File: tb/ecc_page_gen_bench.sv
`timescale 1ns/1ps
module ecc_page_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dat_vld = 1'b0;
    logic [7:0]  dat_byte = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  sts_in = 8'h5A;

    int checks = 0;
    int fails  = 0;
    logic [7:0] page [256];

    always #10 clk = ~clk;

    ecc_page_gen u_ecc_page_gen (
        .clk(clk), .rst_n(rst_n), .dat_vld(dat_vld), .dat_byte(dat_byte),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sts_in(sts_in)
    );

    // Expected {off3, off2, off1} over the first n bytes of page.
    function automatic logic [23:0] model(input int n, input logic inv);
        logic [7:0]  masks [6];
        logic [15:0] lp;
        logic [5:0]  cp;
        logic [7:0]  hi, lo, cb;
        masks[0] = 8'h55; masks[1] = 8'hAA; masks[2] = 8'h33;
        masks[3] = 8'hCC; masks[4] = 8'h0F; masks[5] = 8'hF0;
        lp = '0; cp = '0;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 6; k++) cp[k] ^= ^(page[i] & masks[k]);
            if (^page[i]) begin
                for (int k = 0; k < 8; k++) begin
                    if ((i >> k) & 1) lp[2*k+1] ^= 1'b1;
                    else              lp[2*k]   ^= 1'b1;
                end
            end
        end
        hi = lp[15:8]; lo = lp[7:0]; cb = {cp, 2'b00};
        if (inv) begin hi = ~hi; lo = ~lo; cb = {~cp, 2'b11}; end
        return {cb, lo, hi};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        rd_addr = 4'(a);
        #1;
        v = rd_data;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        dat_vld = 1'b1; dat_byte = b;
        @(negedge clk);
        dat_vld = 1'b0;
    endtask

    task automatic check_code(input string req, input int n, input logic inv);
        logic [31:0] v1, v2, v3, v0;
        logic [23:0] e;
        e = model(n, inv);
        rd(1, v1); rd(2, v2); rd(3, v3); rd(0, v0);
        check(req, {v3[7:0], v2[7:0], v1[7:0]}, {8'h0, e});
        check({req, " R5 word"}, v0, {e[23:16], e[15:8], e[7:0], sts_in});
    endtask

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5, v); check("R1 ctl", v, 32'h0);
        rd(1, v); check("R1 off1", v, 32'h0);
        rd(2, v); check("R1 off2", v, 32'h0);
        rd(3, v); check("R1 off3", v, 32'h0);

        // R4 erased page
        wr(5, 8'h07);
        rd(5, v); check("R6 ctl readback", v, 32'h05);
        for (int i = 0; i < 256; i++) begin page[i] = 8'hFF; push(8'hFF); end
        check_code("R4 erased", 256, 1'b1);

        // R2 R3 random pages, both forms
        for (int p = 0; p < 4; p++) begin
            logic inv;
            inv = p[0];
            wr(5, inv ? 8'h07 : 8'h03);
            for (int i = 0; i < 256; i++) begin
                page[i] = 8'($urandom);
                push(page[i]);
            end
            sts_in = 8'($urandom);
            check_code(inv ? "R2 R3 inverted page" : "R2 R3 R4 raw page", 256, inv);
        end

        // R10 per-byte visibility
        wr(5, 8'h03);
        for (int i = 0; i < 5; i++) begin
            page[i] = 8'($urandom) | 8'h01;
            push(page[i]);
            check_code("R10 partial", i + 1, 1'b0);
        end

        // R7 enable gap in mid chunk
        wr(5, 8'h07);
        for (int i = 0; i < 10; i++) begin page[i] = 8'($urandom); push(page[i]); end
        wr(5, 8'h04);
        for (int i = 0; i < 5; i++) push(8'($urandom) | 8'h01);
        check_code("R7 disabled bytes", 10, 1'b1);
        wr(5, 8'h05);
        for (int i = 10; i < 256; i++) begin page[i] = 8'($urandom); push(page[i]); end
        check_code("R7 resumed chunk", 256, 1'b1);

        // R8 freeze when full
        for (int i = 0; i < 7; i++) push(8'($urandom) | 8'h01);
        check_code("R8 frozen", 256, 1'b1);

        // R9 writes elsewhere ignored, unmapped reads zero
        wr(1, 8'h00); wr(2, 8'h55); wr(3, 8'hAA); wr(0, 8'h02);
        check_code("R9 stray writes", 256, 1'b1);
        rd(5, v); check("R9 ctl unchanged", v, 32'h05);
        rd(4, v); check("R9 unmapped 4", v, 32'h0);
        rd(9, v); check("R9 unmapped 9", v, 32'h0);

        // R6 clear in the same cycle as a data byte
        wr_en = 1'b1; wr_addr = 4'd5; wr_data = 8'h07;
        dat_vld = 1'b1; dat_byte = 8'h01;
        @(negedge clk);
        wr_en = 1'b0; dat_vld = 1'b0;
        check_code("R6 cleared", 0, 1'b1);
        page[0] = 8'h80; push(8'h80);
        page[1] = 8'h07; push(8'h07);
        check_code("R6 restart index", 2, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule